// File: doc/BRIEF.md
# Subtract-Compare Flag Unit

This unit compares two operands for a small processor datapath. It subtracts the second operand from the first by adding the inverted second operand to the first, with a carry-in of one. The adder is one bit wider than the operands, and its top bit gives the raw carry-out. From the operand-width difference and that carry, the unit forms four condition flags: carry, zero, sign and signed overflow. The flags are captured in a register on a compare strobe and are held there until the next strobe.

A 3-bit condition code picks one branch predicate. The predicate is evaluated against the stored flags at all times. Signed ordering comes from the sign flag combined with the overflow flag, so it stays correct when the difference wraps. Unsigned ordering comes from the raw adder carry.

The parameter `INVERT_BORROW` sets how the carry flag is reported after a subtract:
- Clear: the carry flag reports the adder carry-out as it is.
- Set: the carry flag reports the inverse, which is the borrow convention.

Branch outcomes are the same under both settings. The operand width `W` is a parameter and must be at least 4.

Top module: `cmp_flag_unit`

## Requirements
- R1: With `INVERT_BORROW`=0, `flag_carry` after a compare is 1 exactly when A >= B as unsigned numbers. With `INVERT_BORROW`=1 it is 1 exactly when A < B as unsigned numbers.
- R2: `flag_zero` after a compare is 1 exactly when the W-bit difference A-B is all zeros, that is, when A equals B.
- R3: `flag_sign` after a compare equals bit W-1 of the W-bit difference A-B. The carry bit is not part of this.
- R4: `flag_ovf` after a compare is 1 exactly when the true signed difference A-B falls outside the signed W-bit range. For example, at W=4 with B=5, every A from -4 down to -8 sets it, and A=-4 gives a wrapped difference of +7 with the sign clear.
- R5: The flags change only on a rising clock edge with `cmp_valid` high. On every other edge they keep their value, whatever the operands do.
- R6: A synchronous active-high `rst` clears all four flags.
- R7: `cond_sel` picks the predicate that drives `branch_taken`:
  - 000: equal (zero flag set)
  - 001: not equal
  - 010: signed less-than (sign XOR overflow)
  - 011: signed greater-or-equal
  - 100: unsigned below
  - 101: sign flag
  - 110: overflow flag
  - 111: always taken
- R8: The unsigned-below predicate is 1 exactly when A < B as unsigned numbers. It comes from a raw adder carry of 0 and is the same for both `INVERT_BORROW` settings.
- R9: `branch_taken` follows the stored flags combinationally. In the cycle that carries a compare strobe, it still reflects the flags of the previous compare.
- R10: At W=4 with A=5 and B=5, the raw adder output is 1_0000. The flags are zero set, sign clear and overflow clear. `flag_carry` is 1 when `INVERT_BORROW`=0 and 0 when `INVERT_BORROW`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare strobe: capture the flags of op_a - op_b |
| op_a | input | W | Minuend |
| op_b | input | W | Subtrahend |
| cond_sel | input | 3 | Branch condition code |
| flag_carry | output | 1 | Stored carry flag, polarity set by INVERT_BORROW |
| flag_zero | output | 1 | Stored zero flag |
| flag_sign | output | 1 | Stored sign flag |
| flag_ovf | output | 1 | Stored signed-overflow flag |
| branch_taken | output | 1 | Selected predicate evaluated on the stored flags |

## Verification
Two things can happen in the same cycle: a new compare strobe is loading fresh flags, and a branch is being evaluated on the flags already stored. The bench provokes this on every operand pair. It raises `cmp_valid` with new operands and selects the equal condition. Before the edge, it checks that `branch_taken` still matches the zero flag of the previous compare. After the edge, it judges all four flags and all eight predicates against signed and unsigned arithmetic computed in the bench, for every 4-bit operand pair, on one instance for each carry convention.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    typedef enum logic [2:0] {
        CC_EQ  = 3'b000,
        CC_NE  = 3'b001,
        CC_SLT = 3'b010,
        CC_SGE = 3'b011,
        CC_ULT = 3'b100,
        CC_NEG = 3'b101,
        CC_OVF = 3'b110,
        CC_ALL = 3'b111
    } cond_e;

    localparam int NUM_COND = 8;

endpackage

// File: rtl/cmpf_sub_adder.sv
module cmpf_sub_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output logic         cout,
    output logic         cin_msb
);
    localparam int LOW = W - 1;

    logic [W:0]   full_sum;
    logic [LOW:0] low_sum;

    // Full-width adder: a + ~b + 1, with one extra bit for the carry-out
    assign full_sum = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    // Same sum over the bits below the msb: its top bit is the carry into the msb
    assign low_sum  = {1'b0, a[LOW-1:0]} + {1'b0, ~b[LOW-1:0]} + {{LOW{1'b0}}, 1'b1};

    assign diff    = full_sum[W-1:0];
    assign cout    = full_sum[W];
    assign cin_msb = low_sum[LOW];

endmodule

// File: rtl/cmpf_flag_reg.sv
module cmpf_flag_reg
    import cmpf_pkg::*;
#(
    parameter bit INVERT_BORROW = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t raw_flags,
    output flags_t cur_flags
);
    flags_t next_flags;

    generate
        if (INVERT_BORROW) begin : g_borrow
            always_comb begin
                next_flags   = raw_flags;
                next_flags.c = ~raw_flags.c;
            end
        end else begin : g_carry
            always_comb next_flags = raw_flags;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_flags <= '0;
        end else if (load) begin
            cur_flags <= next_flags;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cur_flags == '0)); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur_flags)); // R5

endmodule

// File: rtl/cmpf_cond_eval.sv
module cmpf_cond_eval
    import cmpf_pkg::*;
#(
    parameter bit INVERT_BORROW = 1'b0
) (
    input  flags_t               flags,
    input  logic [2:0]           cond_sel,
    output logic [NUM_COND-1:0]  preds,
    output logic                 taken
);
    logic raw_carry;

    // Recover the adder carry-out so unsigned ordering ignores the flag convention
    generate
        if (INVERT_BORROW) begin : g_unflip
            assign raw_carry = ~flags.c;
        end else begin : g_direct
            assign raw_carry = flags.c;
        end
    endgenerate

    always_comb begin
        preds         = '0;
        preds[CC_EQ]  = flags.z;
        preds[CC_NE]  = ~flags.z;
        preds[CC_SLT] = flags.s ^ flags.v;
        preds[CC_SGE] = ~(flags.s ^ flags.v);
        preds[CC_ULT] = ~raw_carry;
        preds[CC_NEG] = flags.s;
        preds[CC_OVF] = flags.v;
        preds[CC_ALL] = 1'b1;
    end

    always_comb begin
        unique case (cond_e'(cond_sel))
            CC_EQ:   taken = preds[CC_EQ];
            CC_NE:   taken = preds[CC_NE];
            CC_SLT:  taken = preds[CC_SLT];
            CC_SGE:  taken = preds[CC_SGE];
            CC_ULT:  taken = preds[CC_ULT];
            CC_NEG:  taken = preds[CC_NEG];
            CC_OVF:  taken = preds[CC_OVF];
            CC_ALL:  taken = preds[CC_ALL];
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmpf_pkg::*;
#(
    parameter int W             = 8,
    parameter bit INVERT_BORROW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   cond_sel,
    output logic         flag_carry,
    output logic         flag_zero,
    output logic         flag_sign,
    output logic         flag_ovf,
    output logic         branch_taken
);
    localparam int MSB = W - 1;

    logic [W-1:0]        diff;
    logic                cout;
    logic                cin_msb;
    flags_t              raw_flags;
    flags_t              cur_flags;
    logic [NUM_COND-1:0] preds;

    cmpf_sub_adder #(.W(W)) u_adder (
        .a       (op_a),
        .b       (op_b),
        .diff    (diff),
        .cout    (cout),
        .cin_msb (cin_msb)
    );

    always_comb begin
        raw_flags.c = cout;
        raw_flags.z = ~|diff;
        raw_flags.s = diff[MSB];
        raw_flags.v = cin_msb ^ cout;
    end

    cmpf_flag_reg #(.INVERT_BORROW(INVERT_BORROW)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .load      (cmp_valid),
        .raw_flags (raw_flags),
        .cur_flags (cur_flags)
    );

    cmpf_cond_eval #(.INVERT_BORROW(INVERT_BORROW)) u_cond (
        .flags    (cur_flags),
        .cond_sel (cond_sel),
        .preds    (preds),
        .taken    (branch_taken)
    );

    assign flag_carry = cur_flags.c;
    assign flag_zero  = cur_flags.z;
    assign flag_sign  = cur_flags.s;
    assign flag_ovf   = cur_flags.v;

    // Independent difference, used only by the checks below
    logic [W-1:0] chk_diff;
    assign chk_diff = op_a - op_b;

    AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> (flag_zero == ($past(op_a) == $past(op_b)))); // R2
    AST_SIGN_MSB: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> (flag_sign == $past(chk_diff[MSB]))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> (flag_ovf == (($past(op_a[MSB]) != $past(op_b[MSB])) &&
                                    ($past(chk_diff[MSB]) != $past(op_a[MSB]))))); // R4
    AST_BELOW_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> (preds[CC_ULT] == ($past(op_a) < $past(op_b)))); // R8

endmodule

// File: tb/cmp_flag_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmp_valid;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [2:0]   cond_sel;

    logic c0, z0, s0, v0, br0;
    logic c1, z1, s1, v1, br1;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cmp_flag_unit #(.W(W), .INVERT_BORROW(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
        .cond_sel(cond_sel), .flag_carry(c0), .flag_zero(z0), .flag_sign(s0),
        .flag_ovf(v0), .branch_taken(br0));

    cmp_flag_unit #(.W(W), .INVERT_BORROW(1'b1)) dut_inv_i (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
        .cond_sel(cond_sel), .flag_carry(c1), .flag_zero(z1), .flag_sign(s1),
        .flag_ovf(v1), .branch_taken(br1));

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int prev_z;
        rst = 1'b1; cmp_valid = 1'b0; op_a = '0; op_b = '0; cond_sel = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.1;
        // R6: reset state
        check("R6", "carry after reset", c0, 0);
        check("R6", "inv carry after reset", c1, 0);
        check("R6", "zero after reset", z0, 0);
        check("R6", "sign after reset", s0, 0);
        check("R6", "ovf after reset", v0, 0);
        cond_sel = 3'b111; #0.2;
        check("R7", "always after reset", br0, 1);
        prev_z = 0;

        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                int sa, sb, sd, res, ez, es, ev, rawc;
                int exp_pred [8];
                sa   = (ia > 7) ? ia - 16 : ia;
                sb   = (ib > 7) ? ib - 16 : ib;
                sd   = sa - sb;
                res  = (ia - ib) & 15;
                ez   = (ia == ib) ? 1 : 0;
                es   = (res >> 3) & 1;
                ev   = (sd > 7 || sd < -8) ? 1 : 0;
                rawc = (ia >= ib) ? 1 : 0;
                exp_pred[0] = ez;
                exp_pred[1] = 1 - ez;
                exp_pred[2] = (sa <  sb) ? 1 : 0;
                exp_pred[3] = (sa >= sb) ? 1 : 0;
                exp_pred[4] = (ia <  ib) ? 1 : 0;
                exp_pred[5] = es;
                exp_pred[6] = ev;
                exp_pred[7] = 1;

                // Strobe and branch evaluation in the same cycle
                @(negedge clk);
                op_a = W'(ia); op_b = W'(ib); cmp_valid = 1'b1; cond_sel = 3'b000;
                #0.2;
                check("R9", "eq before strobe edge", br0, prev_z);
                check("R9", "inv eq before strobe edge", br1, prev_z);

                @(negedge clk);
                cmp_valid = 1'b0;
                #0.1;
                check("R1", "carry", c0, rawc);
                check("R1", "inv carry", c1, 1 - rawc);
                check("R2", "zero", z0, ez);
                check("R2", "inv zero", z1, ez);
                check("R3", "sign", s0, es);
                check("R3", "inv sign", s1, es);
                check("R4", "ovf", v0, ev);
                check("R4", "inv ovf", v1, ev);
                if (ib == 5 && ia >= 8 && ia <= 12) begin
                    check("R4", "ovf for A in -8..-4, B=5", v0, 1);
                    if (ia == 12) check("R4", "A=-4 wraps positive", s0, 0);
                end
                if (ia == 5 && ib == 5) begin
                    check("R10", "5-5 carry", c0, 1);
                    check("R10", "5-5 inv carry", c1, 0);
                    check("R10", "5-5 zero", z0, 1);
                    check("R10", "5-5 sign", s0, 0);
                    check("R10", "5-5 ovf", v0, 0);
                end
                for (int c = 0; c < 8; c++) begin
                    cond_sel = 3'(c);
                    #0.2;
                    check(c == 4 ? "R8" : "R7", $sformatf("pred %0d", c), br0, exp_pred[c]);
                    check(c == 4 ? "R8" : "R7", $sformatf("inv pred %0d", c), br1, exp_pred[c]);
                end

                // Operands move without a strobe: flags must hold
                op_a = W'(ia ^ 9); op_b = W'(ib ^ 6);
                @(negedge clk);
                #0.1;
                check("R5", "carry hold", c0, rawc);
                check("R5", "zero hold", z0, ez);
                check("R5", "sign hold", s0, es);
                check("R5", "ovf hold", v1, ev);
                prev_z = ez;
            end
        end

        // Reset after a compare that set the zero flag
        @(negedge clk);
        op_a = 4'd3; op_b = 4'd3; cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0; #0.1;
        check("R2", "zero before reset", z0, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #0.1;
        check("R6", "zero cleared by reset", z0, 0);
        check("R6", "carry cleared by reset", c0, 0);
        check("R6", "inv carry cleared by reset", c1, 0);

        summary();
        $finish;
    end

endmodule